// File: doc/BRIEF.md
# Extra-Link Aware Next-Hop Router

This block makes the per-node routing decision in a 4x4 torus whose fixed base network is supplemented by reconfigurable extra links, one per node. A header arrives carrying a destination node, a two-bit virtual-channel class and the request/reply distinction folded into that class. One cycle later the block returns the output port and the outgoing virtual channel. The output port is one of four torus directions, this node's extra link, or eject.

A reloadable table holds one entry per destination. Each entry names one of three actions. The packet may cross this node's extra link, head over the base network toward the node where a chosen extra link starts, or go straight to the destination. All base-network travel is dimension-ordered. X is resolved before Y, each ring is taken the short way round, and a half-ring tie goes in the positive direction. A packet crosses at most one extra link. On crossing, it moves into a second request/reply pair of virtual channels, and from then on it ignores table entries. The table is rewritten whenever the extra links are reconfigured.

A two-state mode machine gates use of the extra links. In state DIRECT_ONLY, every entry is treated as direct routing. In state LINKS_ON, the table is obeyed. The transition DIRECT_ONLY to LINKS_ON is taken on a clock edge where `xl_en` is high, and LINKS_ON to DIRECT_ONLY on an edge where it is low. Reset enters DIRECT_ONLY.

Top module: `xl_next_hop_router`

## Requirements
- R1: After reset, `out_valid` is 0, the mode is DIRECT_ONLY and every table entry holds the direct action (code 0).
- R2: A header presented with `hdr_valid` high on a clock edge gives `out_valid` high with its decision after that edge, and `out_valid` is 0 after an edge where `hdr_valid` was low.
- R3: A header whose destination equals `node_id` is given port EJECT (code 0) with its virtual channel unchanged, whatever the table holds.
- R4: Base-network steps are dimension-ordered. Node index bits [1:0] are X and bits [3:2] are Y, and X is corrected first. A forward ring distance of 1 gives the positive port, 3 gives the negative port, and 2 (the tie) gives the positive port. The port codes are XPOS=1, XNEG=2, YPOS=3 and YNEG=4.
- R5: The direct action (code 0, and also the unused code 3) routes by R4 toward the destination and leaves the virtual channel unchanged.
- R6: The local-link action (code 1) gives port XLINK (code 5). The outgoing virtual channel has bit 1 (post-extra-link set) set and bit 0 (reply) copied from the input.
- R7: The remote-start action (code 2) routes by R4 toward the entry's start node with the virtual channel unchanged. If that start node is this node, it behaves as R6.
- R8: A header already on the post-extra-link set (`hdr_vc[1]`=1) ignores its table entry and routes by R5.
- R9: In mode DIRECT_ONLY, every entry is treated as direct. A change of `xl_en` applies to headers presented from the following clock edge on.
- R10: A table write applies to headers from the next edge on. A header presented on the same edge as a write to its own entry is routed with the old entry.
- R11: Bit 0 of `out_vc` always equals bit 0 of the header's `hdr_vc`, and port XLINK is only ever paired with bit 1 of `out_vc` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 4 | Index of this node, X in bits [1:0] |
| xl_en | input | 1 | Extra links usable (drives the mode machine) |
| tbl_we | input | 1 | Table write strobe |
| tbl_dest | input | 4 | Destination entry being written |
| tbl_act | input | 2 | Action: 0 direct, 1 local link, 2 remote start |
| tbl_start | input | 4 | Start node used by the remote-start action |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_dest | input | 4 | Header destination node |
| hdr_vc | input | 2 | Header class: bit 1 post-link set, bit 0 reply |
| out_valid | output | 1 | Decision valid |
| out_port | output | 3 | 0 eject, 1 XPOS, 2 XNEG, 3 YPOS, 4 YNEG, 5 XLINK |
| out_vc | output | 2 | Outgoing virtual-channel class |

## Verification
Random headers over random nodes, destinations, classes and table contents are run with the links switched on and off, against a reference computed in the bench. This separates the three table actions from one another and from the post-link and disabled overrides. Directed cases cover the half-ring tie in both dimensions, which shows whether ties are broken positively, and a remote start equal to the current node, which shows whether the link is crossed rather than the packet ejected. A write to an entry on the same edge as a header for it tells old-entry use from new-entry use. An `xl_en` toggle just before a header shows the one-edge delay of the mode machine.

// File: rtl/xlr_pkg.sv
package xlr_pkg;
    typedef enum logic [2:0] {
        P_EJECT = 3'd0,
        P_XPOS  = 3'd1,
        P_XNEG  = 3'd2,
        P_YPOS  = 3'd3,
        P_YNEG  = 3'd4,
        P_XLINK = 3'd5
    } port_e;

    typedef enum logic [1:0] {
        A_DIRECT = 2'd0,
        A_LOCAL  = 2'd1,
        A_REMOTE = 2'd2,
        A_SPARE  = 2'd3
    } act_e;

    typedef enum logic {
        ST_DIRECT_ONLY = 1'b0,
        ST_LINKS_ON    = 1'b1
    } mode_e;
endpackage

// File: rtl/xlr_dor.sv
module xlr_dor
    import xlr_pkg::*;
#(
    parameter int XW = 2,
    parameter int YW = 2,
    parameter int NW = XW + YW
) (
    input  logic [NW-1:0] here,
    input  logic [NW-1:0] target,
    output port_e         dir
);
    localparam logic [XW-1:0] HALF_X = XW'(1 << (XW - 1));
    localparam logic [YW-1:0] HALF_Y = YW'(1 << (YW - 1));

    logic [XW-1:0] fwd_x;
    logic [YW-1:0] fwd_y;

    // forward ring distance, wraps naturally in the field width
    assign fwd_x = target[XW-1:0] - here[XW-1:0];
    assign fwd_y = target[NW-1:XW] - here[NW-1:XW];

    always_comb begin
        if (fwd_x != '0)
            dir = (fwd_x <= HALF_X) ? P_XPOS : P_XNEG;
        else if (fwd_y != '0)
            dir = (fwd_y <= HALF_Y) ? P_YPOS : P_YNEG;
        else
            dir = P_EJECT;
    end
endmodule

// File: rtl/xlr_table.sv
module xlr_table #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [NW-1:0] waddr,
    input  logic [1:0]    wact,
    input  logic [NW-1:0] wstart,
    input  logic [NW-1:0] raddr,
    output logic [1:0]    ract,
    output logic [NW-1:0] rstart
);
    localparam int ENTRIES = 1 << NW;

    logic [1:0]    act_w   [ENTRIES];
    logic [NW-1:0] start_w [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [1:0]    act_q;
        logic [NW-1:0] start_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q   <= 2'd0;
                start_q <= '0;
            end else if (we && waddr == NW'(g)) begin
                act_q   <= wact;
                start_q <= wstart;
            end
        end

        assign act_w[g]   = act_q;
        assign start_w[g] = start_q;
    end

    assign ract   = act_w[raddr];
    assign rstart = start_w[raddr];
endmodule

// File: rtl/xl_next_hop_router.sv
module xl_next_hop_router
    import xlr_pkg::*;
#(
    parameter int XW = 2,
    parameter int YW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [XW+YW-1:0]     node_id,
    input  logic                 xl_en,
    input  logic                 tbl_we,
    input  logic [XW+YW-1:0]     tbl_dest,
    input  logic [1:0]           tbl_act,
    input  logic [XW+YW-1:0]     tbl_start,
    input  logic                 hdr_valid,
    input  logic [XW+YW-1:0]     hdr_dest,
    input  logic [1:0]           hdr_vc,
    output logic                 out_valid,
    output logic [2:0]           out_port,
    output logic [1:0]           out_vc
);
    localparam int NW = XW + YW;

    mode_e         mode_q, mode_d;
    logic [1:0]    ent_act;
    logic [NW-1:0] ent_start;
    port_e         dir_dest, dir_start;
    act_e          eff_act;
    port_e         port_d;
    logic [1:0]    vc_d;

    xlr_table #(.NW(NW)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we),
        .waddr  (tbl_dest),
        .wact   (tbl_act),
        .wstart (tbl_start),
        .raddr  (hdr_dest),
        .ract   (ent_act),
        .rstart (ent_start)
    );

    xlr_dor #(.XW(XW), .YW(YW), .NW(NW)) u_dor_dest (
        .here   (node_id),
        .target (hdr_dest),
        .dir    (dir_dest)
    );

    xlr_dor #(.XW(XW), .YW(YW), .NW(NW)) u_dor_start (
        .here   (node_id),
        .target (ent_start),
        .dir    (dir_start)
    );

    // mode machine: next state
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            ST_DIRECT_ONLY: if (xl_en)  mode_d = ST_LINKS_ON;
            ST_LINKS_ON:    if (!xl_en) mode_d = ST_DIRECT_ONLY;
            default:        mode_d = ST_DIRECT_ONLY;
        endcase
    end

    // mode machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= ST_DIRECT_ONLY;
        else        mode_q <= mode_d;
    end

    // action after the overrides: disabled links and post-link class
    always_comb begin
        eff_act = act_e'(ent_act);
        if (mode_q == ST_DIRECT_ONLY || hdr_vc[1] || eff_act == A_SPARE)
            eff_act = A_DIRECT;
    end

    always_comb begin
        port_d = dir_dest;
        vc_d   = hdr_vc;
        if (hdr_dest != node_id) begin
            unique case (eff_act)
                A_LOCAL: begin
                    port_d = P_XLINK;
                    vc_d   = {1'b1, hdr_vc[0]};
                end
                A_REMOTE: begin
                    if (ent_start == node_id) begin
                        port_d = P_XLINK;
                        vc_d   = {1'b1, hdr_vc[0]};
                    end else begin
                        port_d = dir_start;
                    end
                end
                default: port_d = dir_dest;
            endcase
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_port  <= P_EJECT;
            out_vc    <= 2'd0;
        end else begin
            out_valid <= hdr_valid;
            if (hdr_valid) begin
                out_port <= port_d;
                out_vc   <= vc_d;
            end
        end
    end
endmodule

// File: rtl/xlr_chk.sv
module xlr_chk #(
    parameter int NW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NW-1:0] node_id,
    input logic          hdr_valid,
    input logic [NW-1:0] hdr_dest,
    input logic [1:0]    hdr_vc,
    input logic          mode_q,
    input logic          out_valid,
    input logic [2:0]    out_port,
    input logic [1:0]    out_vc
);
    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !out_valid);

    // R3
    eject_here_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> ((out_port == 3'd0) == ($past(hdr_dest) == $past(node_id))));

    // R8
    post_set_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_vc[1]) |=> (out_port != 3'd5));

    // R9
    disabled_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !mode_q) |=> (out_port != 3'd5));

    // R11
    reply_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> (out_vc[0] == $past(hdr_vc[0])));

    // R11
    link_sets_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port == 3'd5) |-> out_vc[1]);

    // R4
    legal_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_port <= 3'd5));
endmodule

bind xl_next_hop_router xlr_chk #(.NW(NW)) u_xlr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .node_id   (node_id),
    .hdr_valid (hdr_valid),
    .hdr_dest  (hdr_dest),
    .hdr_vc    (hdr_vc),
    .mode_q    (mode_q),
    .out_valid (out_valid),
    .out_port  (out_port),
    .out_vc    (out_vc)
);

// File: tb/test_xl_next_hop_router.sv
module test_xl_next_hop_router;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] node_id;
    logic       xl_en;
    logic       tbl_we;
    logic [3:0] tbl_dest;
    logic [1:0] tbl_act;
    logic [3:0] tbl_start;
    logic       hdr_valid;
    logic [3:0] hdr_dest;
    logic [1:0] hdr_vc;
    logic       out_valid;
    logic [2:0] out_port;
    logic [1:0] out_vc;

    int checks = 0;
    int fails  = 0;

    logic [1:0] m_act   [16];
    logic [3:0] m_start [16];
    bit         m_on;

    always #5 clk = ~clk;

    xl_next_hop_router i_xl_next_hop_router (
        .clk(clk), .rst_n(rst_n), .node_id(node_id), .xl_en(xl_en),
        .tbl_we(tbl_we), .tbl_dest(tbl_dest), .tbl_act(tbl_act), .tbl_start(tbl_start),
        .hdr_valid(hdr_valid), .hdr_dest(hdr_dest), .hdr_vc(hdr_vc),
        .out_valid(out_valid), .out_port(out_port), .out_vc(out_vc)
    );

    function automatic logic [2:0] ref_step(int me, int to);
        int mx = me % 4, my = me / 4, tx = to % 4, ty = to / 4;
        int ddx = (tx - mx + 4) % 4;
        int ddy = (ty - my + 4) % 4;
        if (ddx != 0) return (ddx <= 2) ? 3'd1 : 3'd2;
        if (ddy != 0) return (ddy <= 2) ? 3'd3 : 3'd4;
        return 3'd0;
    endfunction

    function automatic logic [4:0] ref_route(int me, int dst, logic [1:0] vc,
                                             logic [1:0] act, int st, bit on);
        if (dst == me) return {3'd0, vc};
        if (!on || vc[1] || act == 2'd0 || act == 2'd3) return {ref_step(me, dst), vc};
        if (act == 2'd1 || st == me) return {3'd5, 1'b1, vc[0]};
        return {ref_step(me, st), vc};
    endfunction

    function automatic string tag_of(int me, int dst, logic [1:0] vc, logic [1:0] act, bit on);
        if (dst == me) return "R3";
        if (vc[1]) return "R8";
        if (!on) return "R9";
        if (act == 2'd1) return "R6";
        if (act == 2'd2) return "R7";
        return "R5";
    endfunction

    task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got port=%0d vc=%0d expected port=%0d vc=%0d",
                     tag, got[4:2], got[1:0], exp[4:2], exp[1:0]);
        end
    endtask

    // drive one cycle at a negedge, then check the registered result
    task automatic cycle(bit hv, int me, int dst, logic [1:0] vc, bit en,
                         bit we, int wd, logic [1:0] wa, int ws, string tag);
        logic [4:0] exp;
        string t;
        node_id = 4'(me); hdr_valid = hv; hdr_dest = 4'(dst); hdr_vc = vc;
        xl_en = en; tbl_we = we; tbl_dest = 4'(wd); tbl_act = wa; tbl_start = 4'(ws);
        exp = ref_route(me, dst, vc, m_act[dst], int'(m_start[dst]), m_on);
        t = (tag == "") ? tag_of(me, dst, vc, m_act[dst], m_on) : tag;
        if (we) begin m_act[wd] = wa; m_start[wd] = 4'(ws); end
        m_on = en;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== hv) begin
            fails++;
            $display("FAIL R2: out_valid=%0b expected %0b", out_valid, hv);
        end
        if (hv) check(t, {out_port, out_vc}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(1234);
        for (int i = 0; i < 16; i++) begin m_act[i] = 2'd0; m_start[i] = 4'd0; end
        m_on = 1'b0;
        rst_n = 1'b0; node_id = 4'd0; xl_en = 1'b0; tbl_we = 1'b0; tbl_dest = 4'd0;
        tbl_act = 2'd0; tbl_start = 4'd0; hdr_valid = 1'b0; hdr_dest = 4'd0; hdr_vc = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_valid=%0b expected 0", out_valid);
        end
        rst_n = 1'b1;
        // R1: mode starts DIRECT_ONLY, entries direct: node 0 to node 5 goes XPOS
        cycle(1, 0, 5, 2'b00, 0, 0, 0, 0, 0, "R1");
        // R4 ties: node 0 -> x=2 (XPOS), node 0 -> y=2 (YPOS), node 0 -> x=3 (XNEG), y=3 (YNEG)
        cycle(1, 0, 2, 2'b01, 0, 0, 0, 0, 0, "R4");
        cycle(1, 0, 8, 2'b00, 0, 0, 0, 0, 0, "R4");
        cycle(1, 0, 3, 2'b00, 0, 0, 0, 0, 0, "R4");
        cycle(1, 0, 12, 2'b01, 0, 0, 0, 0, 0, "R4");
        cycle(1, 5, 5, 2'b11, 0, 0, 0, 0, 0, "R3");
        // install entries while links disabled, then R9: still direct
        cycle(0, 0, 0, 2'b00, 0, 1, 10, 2'd1, 0, "");
        cycle(0, 0, 0, 2'b00, 0, 1, 11, 2'd2, 6, "");
        cycle(1, 5, 10, 2'b00, 1, 0, 0, 0, 0, "R9");
        cycle(1, 5, 10, 2'b01, 1, 0, 0, 0, 0, "R6");
        cycle(1, 5, 11, 2'b00, 1, 0, 0, 0, 0, "R7");
        cycle(1, 6, 11, 2'b01, 1, 0, 0, 0, 0, "R7");
        cycle(1, 5, 10, 2'b10, 1, 0, 0, 0, 0, "R8");
        cycle(1, 5, 10, 2'b01, 1, 0, 0, 0, 0, "R11");
        // R10: write entry 10 to direct in the same cycle as a header to 10
        cycle(1, 5, 10, 2'b00, 1, 1, 10, 2'd0, 0, "R10");
        cycle(1, 5, 10, 2'b00, 1, 0, 0, 0, 0, "R10");
        // R9: disable takes effect one edge later
        cycle(1, 5, 11, 2'b00, 0, 0, 0, 0, 0, "R9");
        cycle(1, 5, 11, 2'b00, 0, 0, 0, 0, 0, "R9");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            bit hv = ($urandom % 4) != 0;
            bit en = ($urandom % 8) != 0;
            bit we = ($urandom % 3) == 0;
            cycle(hv, int'($urandom % 16), int'($urandom % 16), 2'($urandom % 4), en,
                  we, int'($urandom % 16), 2'($urandom % 4), int'($urandom % 16), "");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule